// File: doc/BRIEF.md
# Acknowledged-Transmit Transaction Sequencer

This block runs one acknowledged transmit transaction inside the digital baseband of a packet radio. From an idle, transmit-ready state, a start command makes it request a frame transmission from the modulator. When the modulator reports that the frame has gone out, the sequencer switches the radio to receive and waits for an acknowledgment frame. The acknowledgment has to begin within a fixed deadline, which is one receive/transmit turnaround plus one unit backoff period. Both lengths are parameters in clock cycles.

A single busy flag covers the whole transaction: the transmit, the wait and the acknowledgment reception. A 3-bit result code holds the outcome. The codes are plain success, success with the frame-pending bit set, still waiting for the acknowledgment, no acknowledgment, and invalid. When the transaction closes, the block raises a one-cycle end interrupt and returns to idle. The modulator, the frame parser and the FCS check are outside the block and appear only as strobes. A strobe that asserts the acknowledgment was received stands for a frame that has already been parsed and checked.

Top module: `ack_tx_seq`

## Requirements
- R1: After reset, busy_o, tx_req_o, rx_on_o and irq_o are 0 and result_o is 7 (INVALID).
- R2: When start_i is high at a clock edge while idle, then from the next cycle busy_o=1, tx_req_o=1 and result_o=7.
- R3: When tx_done_i is high at an edge during transmit, then from the next cycle tx_req_o=0, rx_on_o=1 and result_o=3 (SUCCESS_WAIT_FOR_ACK).
- R4: busy_o stays 1 without a break from the cycle after an accepted start until the cycle in which irq_o is 1; in that cycle busy_o is 0.
- R5: If ack_rx_i is high with ack_pend_i=0 while an acknowledgment is being received, then in the next cycle result_o=0 (SUCCESS), irq_o=1, busy_o=0 and rx_on_o=0.
- R6: The same event with ack_pend_i=1 gives result_o=1 (SUCCESS_DATA_PENDING) with the same irq_o, busy_o and rx_on_o behaviour.
- R7: Let W = TURN_CYC + BACKOFF_CYC. An ack_start_i seen in any of the first W cycles of the wait is accepted. If none is seen, the cycle after the W-th wait cycle shows result_o=5 (NO_ACK), irq_o=1 and busy_o=0.
- R8: A start_i while busy_o=1 is ignored. It does not change tx_req_o or result_o, and no new transaction follows the current one.
- R9: irq_o is high for exactly one cycle per transaction and is never high in two consecutive cycles.
- R10: Strobes outside their phase are ignored. This covers ack_rx_i before ack_start_i was accepted, tx_done_i or ack_start_i while idle, and ack_start_i during transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-transaction command |
| tx_done_i | input | 1 | Frame transmission finished strobe |
| ack_start_i | input | 1 | Acknowledgment frame start detected strobe |
| ack_rx_i | input | 1 | Valid acknowledgment received strobe |
| ack_pend_i | input | 1 | Frame-pending bit of the received acknowledgment, valid with ack_rx_i |
| tx_req_o | output | 1 | Frame transmit request, high during transmit |
| rx_on_o | output | 1 | Receiver enable, high during wait and acknowledgment reception |
| busy_o | output | 1 | Transaction-in-progress status |
| result_o | output | 3 | Result code: 0 SUCCESS, 1 SUCCESS_DATA_PENDING, 3 SUCCESS_WAIT_FOR_ACK, 5 NO_ACK, 7 INVALID |
| irq_o | output | 1 | End-of-transaction interrupt pulse |

## Verification
The bench aims acknowledgment starts at the last accepted wait cycle. A deadline counter that is off by one would report NO_ACK there, or would still accept a start one cycle later. It also runs a wait with no acknowledgment to the end and checks that NO_ACK appears in exactly the cycle after the window. A late strobe is then checked to restart nothing. It sends start commands and acknowledgment strobes at the wrong moments. A sequencer that restarts while busy, or that closes on an acknowledgment received before its start was seen, would change the status or the result code. The frame-pending bit is tried both ways, so a design that drops it would report SUCCESS for both.

// File: rtl/ack_tx_pkg.sv
package ack_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TX,
    ST_WAIT,
    ST_ACK
  } seq_state_e;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_OK_PEND = 3'd1,
    RES_WAIT    = 3'd3,
    RES_NO_ACK  = 3'd5,
    RES_INVALID = 3'd7
  } result_e;

  typedef struct packed {
    logic launch;
    logic enter_wait;
    logic ack_ok;
    logic ack_pend;
    logic no_ack;
  } seq_evt_t;

endpackage

// File: rtl/ack_deadline_cnt.sv
module ack_deadline_cnt #(
  parameter int unsigned WIN_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);

  generate
    if (WIN_CYC <= 1) begin : g_single
      // one-cycle window: every wait cycle is the last one
      assign last_o = 1'b1;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (load_i) begin
          cnt_q <= CNT_W'(WIN_CYC);
        end else if (dec_i && (cnt_q != '0)) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end

      assign last_o = (cnt_q == CNT_W'(1));
    end
  endgenerate

endmodule

// File: rtl/ack_tx_ctrl.sv
module ack_tx_ctrl
  import ack_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tx_done_i,
  input  logic       ack_start_i,
  input  logic       ack_rx_i,
  input  logic       ack_pend_i,
  input  logic       win_last_i,
  output seq_state_e state_o,
  output seq_evt_t   evt_o,
  output logic       cnt_load_o,
  output logic       cnt_dec_o
);
  seq_state_e state_q, state_d;
  seq_evt_t   evt;

  always_comb begin
    state_d = state_q;
    evt     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_TX;
          evt.launch = 1'b1;
        end
      end
      ST_TX: begin
        if (tx_done_i) begin
          state_d        = ST_WAIT;
          evt.enter_wait = 1'b1;
        end
      end
      ST_WAIT: begin
        // an ACK start on the last window cycle still counts
        if (ack_start_i) begin
          state_d = ST_ACK;
        end else if (win_last_i) begin
          state_d    = ST_IDLE;
          evt.no_ack = 1'b1;
        end
      end
      ST_ACK: begin
        if (ack_rx_i) begin
          state_d      = ST_IDLE;
          evt.ack_ok   = 1'b1;
          evt.ack_pend = ack_pend_i;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o    = state_q;
  assign evt_o      = evt;
  assign cnt_load_o = evt.enter_wait;
  assign cnt_dec_o  = (state_q == ST_WAIT);

endmodule

// File: rtl/ack_result_reg.sv
module ack_result_reg
  import ack_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_evt_t   evt_i,
  output logic [2:0] result_o,
  output logic       irq_o
);
  logic [2:0] result_q;
  logic       irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= RES_INVALID;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= evt_i.ack_ok | evt_i.no_ack;
      if (evt_i.launch)          result_q <= RES_INVALID;
      else if (evt_i.enter_wait) result_q <= RES_WAIT;
      else if (evt_i.ack_ok)     result_q <= evt_i.ack_pend ? RES_OK_PEND : RES_OK;
      else if (evt_i.no_ack)     result_q <= RES_NO_ACK;
    end
  end

  assign result_o = result_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/ack_tx_seq.sv
module ack_tx_seq
  import ack_tx_pkg::*;
#(
  parameter int unsigned TURN_CYC    = 12,
  parameter int unsigned BACKOFF_CYC = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tx_done_i,
  input  logic       ack_start_i,
  input  logic       ack_rx_i,
  input  logic       ack_pend_i,
  output logic       tx_req_o,
  output logic       rx_on_o,
  output logic       busy_o,
  output logic [2:0] result_o,
  output logic       irq_o
);
  localparam int unsigned WIN_CYC = TURN_CYC + BACKOFF_CYC;

  seq_state_e state;
  seq_evt_t   evt;
  logic       cnt_load, cnt_dec, win_last;

  ack_tx_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tx_done_i  (tx_done_i),
    .ack_start_i(ack_start_i),
    .ack_rx_i   (ack_rx_i),
    .ack_pend_i (ack_pend_i),
    .win_last_i (win_last),
    .state_o    (state),
    .evt_o      (evt),
    .cnt_load_o (cnt_load),
    .cnt_dec_o  (cnt_dec)
  );

  ack_deadline_cnt #(.WIN_CYC(WIN_CYC)) u_deadline (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cnt_load),
    .dec_i (cnt_dec),
    .last_o(win_last)
  );

  ack_result_reg u_result (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .result_o(result_o),
    .irq_o   (irq_o)
  );

  assign busy_o   = (state != ST_IDLE);
  assign tx_req_o = (state == ST_TX);
  assign rx_on_o  = (state == ST_WAIT) || (state == ST_ACK);

endmodule

// File: rtl/ack_tx_seq_chk.sv
module ack_tx_seq_chk #(
  parameter int unsigned WIN_CYC = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       ack_start_i,
  input logic       tx_req_o,
  input logic       rx_on_o,
  input logic       busy_o,
  input logic [2:0] result_o,
  input logic       irq_o
);
  localparam int unsigned CW = $clog2(WIN_CYC + 2) + 1;

  logic [CW-1:0] wait_cnt;
  logic          ack_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_cnt <= '0;
      ack_seen <= 1'b0;
    end else if (!rx_on_o) begin
      wait_cnt <= '0;
      ack_seen <= 1'b0;
    end else begin
      if (ack_start_i) ack_seen <= 1'b1;
      if (!ack_seen && !ack_start_i) wait_cnt <= wait_cnt + CW'(1);
    end
  end

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && tx_req_o && result_o == 3'd7));

  p_wait_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_on_o |-> (busy_o && !tx_req_o && result_o == 3'd3));

  p_irq_ends_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!busy_o && $past(busy_o)));

  p_end_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (result_o == 3'd0 || result_o == 3'd1 || result_o == 3'd5));

  p_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_on_o && !ack_seen) |-> (wait_cnt < CW'(WIN_CYC)));

  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

endmodule

bind ack_tx_seq ack_tx_seq_chk #(.WIN_CYC(TURN_CYC + BACKOFF_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ack_start_i(ack_start_i),
  .tx_req_o   (tx_req_o),
  .rx_on_o    (rx_on_o),
  .busy_o     (busy_o),
  .result_o   (result_o),
  .irq_o      (irq_o)
);

// File: tb/ack_tx_seq_tb_top.sv
`timescale 1ns/1ps
module ack_tx_seq_tb_top;
  localparam int TURN = 12;
  localparam int BACK = 20;
  localparam int WIN  = TURN + BACK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, tx_done = 0, ack_start = 0, ack_rx = 0, ack_pend = 0;
  logic tx_req, rx_on, busy, irq;
  logic [2:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ack_tx_seq #(.TURN_CYC(TURN), .BACKOFF_CYC(BACK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_done_i(tx_done),
    .ack_start_i(ack_start), .ack_rx_i(ack_rx), .ack_pend_i(ack_pend),
    .tx_req_o(tx_req), .rx_on_o(rx_on), .busy_o(busy),
    .result_o(result), .irq_o(irq)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // start -> transmit -> wait, checked step by step
  task automatic launch_and_send();
    start = 1; tick(); start = 0;
    chk("R2 busy after start", busy, 1);
    chk("R2 tx_req after start", tx_req, 1);
    chk("R2 result during tx", result, 7);
    tx_done = 1; tick(); tx_done = 0;
    chk("R3 tx_req dropped", tx_req, 0);
    chk("R3 rx_on in wait", rx_on, 1);
    chk("R3 result wait code", result, 3);
    chk("R4 busy in wait", busy, 1);
  endtask

  task automatic finish_ack(input logic pend, input int exp_res, input string tag);
    ack_rx = 1; ack_pend = pend; tick(); ack_rx = 0; ack_pend = 0;
    chk({tag, " result"}, result, exp_res);
    chk({tag, " irq"}, irq, 1);
    chk("R4 busy low at irq", busy, 0);
    chk({tag, " rx_on low"}, rx_on, 0);
    tick();
    chk("R9 irq single cycle", irq, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 tx_req", tx_req, 0);
    chk("R1 rx_on", rx_on, 0);
    chk("R1 irq", irq, 0);
    chk("R1 result", result, 7);
  endtask

  task automatic t_idle_strobes();
    tx_done = 1; ack_start = 1; ack_rx = 1; tick();
    tx_done = 0; ack_start = 0; ack_rx = 0;
    chk("R10 idle strobes busy", busy, 0);
    chk("R10 idle strobes irq", irq, 0);
    chk("R10 idle strobes result", result, 7);
  endtask

  task automatic t_plain_success();
    launch_and_send();
    repeat (3) tick();
    ack_start = 1; tick(); ack_start = 0;
    chk("R4 busy during ack", busy, 1);
    finish_ack(1'b0, 0, "R5");
  endtask

  task automatic t_pending_success();
    launch_and_send();
    ack_start = 1; tick(); ack_start = 0;
    finish_ack(1'b1, 1, "R6");
  endtask

  task automatic t_last_cycle_ack();
    launch_and_send();
    repeat (WIN - 1) tick();
    chk("R7 still waiting at last cycle", rx_on, 1);
    ack_start = 1; tick(); ack_start = 0;
    chk("R7 last-cycle ack accepted busy", busy, 1);
    chk("R7 last-cycle ack no irq", irq, 0);
    finish_ack(1'b0, 0, "R7 last-cycle");
  endtask

  task automatic t_no_ack();
    launch_and_send();
    repeat (WIN - 1) tick();
    chk("R7 busy before deadline", busy, 1);
    chk("R7 irq before deadline", irq, 0);
    tick();
    chk("R7 no-ack result", result, 5);
    chk("R7 no-ack irq", irq, 1);
    chk("R7 no-ack busy", busy, 0);
    ack_start = 1; tick(); ack_start = 0;
    chk("R9 no-ack irq single", irq, 0);
    chk("R10 late ack start ignored", busy, 0);
    chk("R10 late ack result kept", result, 5);
  endtask

  task automatic t_start_while_busy();
    start = 1; tick(); start = 0;
    ack_start = 1; start = 1; tick(); start = 0; ack_start = 0;
    chk("R8 start in tx keeps tx_req", tx_req, 1);
    chk("R10 ack start in tx ignored", rx_on, 0);
    chk("R8 start in tx keeps result", result, 7);
    tx_done = 1; tick(); tx_done = 0;
    start = 1; tick(); start = 0;
    chk("R8 start in wait keeps result", result, 3);
    ack_start = 1; tick(); ack_start = 0;
    finish_ack(1'b0, 0, "R8 closing");
    chk("R8 no restart after end", busy, 0);
  endtask

  task automatic t_early_ack_rx();
    launch_and_send();
    ack_rx = 1; ack_pend = 1; tick(); ack_rx = 0; ack_pend = 0;
    chk("R10 early ack_rx no irq", irq, 0);
    chk("R10 early ack_rx still busy", busy, 1);
    chk("R10 early ack_rx result", result, 3);
    ack_start = 1; tick(); ack_start = 0;
    finish_ack(1'b1, 1, "R6 after early strobe");
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_idle_strobes();
    t_plain_success();
    t_pending_success();
    t_last_cycle_ack();
    t_no_ack();
    t_start_while_busy();
    t_early_ack_rx();
    repeat (2) tick();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule